// File: doc/BRIEF.md
# Multichannel Matrix Stream Channelizer

The channelizer collects a batch of Hermitian matrices, one for each channel, and hands them on in an order that a deeply pipelined arithmetic datapath can use. Each matrix arrives as one burst on a valid/channel/data stream. A burst holds only the lower-triangle elements in column-major order, which is T = N*(N+1)/2 words for an NxN matrix. Each 64-bit word is an opaque complex sample with 32-bit I and Q halves. Bursts normally arrive at a fixed spacing: valid is high for T cycles and then low for the rest of the spacing period.

Words are stored in one of two memory banks at slot `channel*T + element`. When the last matrix of a batch is complete, the filled bank is handed to the drain side and the other bank starts filling. The drain side emits the whole batch element-major: element 0 of channels 0..C-1, then element 1 of every channel, and so on. Each output word carries its channel tag, so a downstream stage sees a different channel on each cycle and can hide its per-element latency.

The fill side has two states. FILL_GAP moves to FILL_BURST when valid is high and stays in FILL_GAP otherwise. FILL_BURST stays put while valid is high and returns to FILL_GAP when valid drops. The drain side also has two states. DRAIN_IDLE moves to DRAIN_RUN on a batch hand-over. DRAIN_RUN returns to DRAIN_IDLE once it has issued the read for the last element of the last channel.

Top module: `mcz_channelizer`

## Requirements
- R1: The element index of a sink word is 0 when the word follows a cycle with valid low. Otherwise it is the previous index plus one, and it wraps to 0 after index T-1. The word is stored for channel `in_chan` at that element position.
- R2: The batch is complete when the word with element index T-1 of the CHANNELS-th matrix is accepted. If the drain side is idle, the first output word appears two cycles after the cycle that presented that last sink word.
- R3: Output order is element-major and channel-minor. `out_chan` counts 0..CHANNELS-1 and then restarts for the next element.
- R4: For each handed-over batch, `out_valid` is high for exactly CHANNELS*T consecutive cycles and then goes low.
- R5: The output word for channel c and element k equals the sink word stored for channel c at element k of that batch.
- R6: A new batch may fill while the previous one drains. If a batch completes while the drain side is in DRAIN_RUN, `overflow` rises and that batch is discarded. The bank being drained is never written, so its output is unchanged.
- R7: Once `overflow` is 1 it stays 1 until reset.
- R8: A synchronous active-high reset clears `overflow`, both counters and the bank select, and holds `out_valid` low. A partially received batch is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sink word valid |
| in_chan | input | 8 | Sink channel tag, 0..CHANNELS-1 |
| in_data | input | 64 | Sink word, I and Q halves |
| out_valid | output | 1 | Source word valid |
| out_chan | output | 8 | Source channel tag |
| out_data | output | 64 | Source word |
| overflow | output | 1 | Sticky batch-dropped flag |

## Verification
The bench builds the block with N=3 and CHANNELS=16, so a batch is 96 words. This keeps each batch short enough for many batches to run, including a partial burst, a reset in the middle of a batch and a run of back-to-back bursts. With zero spacing, a second batch completes exactly while the first batch is still draining, which exercises the overflow path and the rule that the draining bank is never written. A spacing of two or three idle cycles shows filling and draining running at the same time without loss.

// File: rtl/mcz_pkg.sv
package mcz_pkg;
    localparam int CHAN_W = 8;
    localparam int DATA_W = 64;

    typedef enum logic {FILL_GAP, FILL_BURST} fill_state_e;
    typedef enum logic {DRAIN_IDLE, DRAIN_RUN} drain_state_e;
endpackage

// File: rtl/mcz_fill_ctrl.sv
module mcz_fill_ctrl
    import mcz_pkg::*;
#(
    parameter int MAT_N    = 4,
    parameter int CHANNELS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CHAN_W-1:0]   in_chan,
    input  logic                drain_busy,
    output logic                wr_en,
    output logic                wr_bank,
    output logic [$clog2(CHANNELS*MAT_N*(MAT_N+1)/2)-1:0] wr_addr,
    output logic                start_drain,
    output logic                overflow
);
    localparam int T     = MAT_N * (MAT_N + 1) / 2;
    localparam int DEPTH = CHANNELS * T;
    localparam int AW    = $clog2(DEPTH);
    localparam int EW    = $clog2(T);
    localparam int MW    = $clog2(CHANNELS);

    fill_state_e state, state_nx;
    logic [EW-1:0] elem_cnt, elem_k;
    logic [MW-1:0] mat_cnt;
    logic          fill_bank;
    logic          last_elem, batch_done;

    always_ff @(posedge clk) begin
        if (rst) state <= FILL_GAP;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FILL_GAP:   if (in_valid)  state_nx = FILL_BURST;
            FILL_BURST: if (!in_valid) state_nx = FILL_GAP;
            default:    state_nx = FILL_GAP;
        endcase
    end

    always_comb begin
        elem_k      = (state == FILL_GAP) ? '0 : elem_cnt;
        last_elem   = in_valid && (elem_k == EW'(T - 1));
        batch_done  = last_elem && (mat_cnt == MW'(CHANNELS - 1));
        wr_en       = in_valid && (int'(in_chan) < CHANNELS);
        wr_bank     = fill_bank;
        wr_addr     = AW'(int'(in_chan) * T + int'(elem_k));
        start_drain = batch_done && !drain_busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elem_cnt  <= '0;
            mat_cnt   <= '0;
            fill_bank <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if (in_valid)
                elem_cnt <= last_elem ? '0 : elem_k + 1'b1;
            if (last_elem)
                mat_cnt <= batch_done ? '0 : mat_cnt + 1'b1;
            if (start_drain)
                fill_bank <= ~fill_bank;
            if (batch_done && drain_busy)
                overflow <= 1'b1;
        end
    end

    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

// File: rtl/mcz_bank_mem.sv
module mcz_bank_mem #(
    parameter int DEPTH  = 160,
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic                     rd_bank,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int IW = $clog2(2 * DEPTH);

    logic [DATA_W-1:0] mem [2*DEPTH];
    logic [IW-1:0]     w_idx, r_idx;

    always_comb begin
        w_idx = IW'(int'(wr_bank) * DEPTH + int'(wr_addr));
        r_idx = IW'(int'(rd_bank) * DEPTH + int'(rd_addr));
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[w_idx] <= wr_data;
        if (rd_en) rd_data    <= mem[r_idx];
    end
endmodule

// File: rtl/mcz_drain_fsm.sv
module mcz_drain_fsm
    import mcz_pkg::*;
#(
    parameter int MAT_N    = 4,
    parameter int CHANNELS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_bank,
    output logic              busy,
    output logic              rd_en,
    output logic              rd_bank,
    output logic [$clog2(CHANNELS*MAT_N*(MAT_N+1)/2)-1:0] rd_addr,
    output logic              out_valid,
    output logic [CHAN_W-1:0] out_chan
);
    localparam int T     = MAT_N * (MAT_N + 1) / 2;
    localparam int DEPTH = CHANNELS * T;
    localparam int AW    = $clog2(DEPTH);
    localparam int EW    = $clog2(T);
    localparam int CW    = $clog2(CHANNELS);

    drain_state_e state, state_nx;
    logic [CW-1:0] chan_idx;
    logic [EW-1:0] elem_idx;
    logic          bank_q;
    logic          chan_last, at_end;

    always_comb begin
        chan_last = (chan_idx == CW'(CHANNELS - 1));
        at_end    = chan_last && (elem_idx == EW'(T - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) state <= DRAIN_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DRAIN_IDLE: if (start)  state_nx = DRAIN_RUN;
            DRAIN_RUN:  if (at_end) state_nx = DRAIN_IDLE;
            default:    state_nx = DRAIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_idx  <= '0;
            elem_idx  <= '0;
            bank_q    <= 1'b0;
            out_valid <= 1'b0;
            out_chan  <= '0;
        end else begin
            out_valid <= (state == DRAIN_RUN);
            out_chan  <= CHAN_W'(chan_idx);
            if (state == DRAIN_IDLE) begin
                chan_idx <= '0;
                elem_idx <= '0;
                if (start) bank_q <= start_bank;
            end else begin
                chan_idx <= chan_last ? '0 : chan_idx + 1'b1;
                if (chan_last) elem_idx <= elem_idx + 1'b1;
            end
        end
    end

    always_comb begin
        busy    = (state == DRAIN_RUN);
        rd_en   = (state == DRAIN_RUN);
        rd_bank = bank_q;
        rd_addr = AW'(int'(chan_idx) * T + int'(elem_idx));
    end

    // R3
    out_chan_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_chan) < CHANNELS));

    // R3
    chan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |->
            (int'(out_chan) == ((int'($past(out_chan)) + 1) % CHANNELS)));
endmodule

// File: rtl/mcz_channelizer.sv
module mcz_channelizer
    import mcz_pkg::*;
#(
    parameter int MAT_N    = 4,
    parameter int CHANNELS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CHAN_W-1:0] out_chan,
    output logic [DATA_W-1:0] out_data,
    output logic              overflow
);
    localparam int T     = MAT_N * (MAT_N + 1) / 2;
    localparam int DEPTH = CHANNELS * T;
    localparam int AW    = $clog2(DEPTH);

    logic          wr_en, wr_bank, start_drain, drain_busy;
    logic          rd_en, rd_bank;
    logic [AW-1:0] wr_addr, rd_addr;

    mcz_fill_ctrl #(.MAT_N(MAT_N), .CHANNELS(CHANNELS)) u_fill (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .drain_busy(drain_busy), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .start_drain(start_drain), .overflow(overflow)
    );

    mcz_bank_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(in_data), .rd_en(rd_en), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .rd_data(out_data)
    );

    mcz_drain_fsm #(.MAT_N(MAT_N), .CHANNELS(CHANNELS)) u_drain (
        .clk(clk), .rst(rst), .start(start_drain), .start_bank(wr_bank),
        .busy(drain_busy), .rd_en(rd_en), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .out_valid(out_valid), .out_chan(out_chan)
    );

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && drain_busy) |-> (wr_bank != rd_bank));
endmodule

// File: tb/mcz_channelizer_test.sv
module mcz_channelizer_test;
    localparam int N  = 3;
    localparam int C  = 16;
    localparam int T  = N * (N + 1) / 2;
    localparam int BW = C * T;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_chan = '0;
    logic [63:0] in_data = '0;
    logic        out_valid, overflow;
    logic [7:0]  out_chan;
    logic [63:0] out_data;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    mcz_channelizer #(.MAT_N(N), .CHANNELS(C)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_data(in_data), .out_valid(out_valid), .out_chan(out_chan),
        .out_data(out_data), .overflow(overflow)
    );

    // behavioural reference
    logic [63:0] fill_buf  [BW];
    logic [63:0] drain_buf [BW];
    int  drain_pos = -1;
    int  m_cnt = 0, m_mats = 0;
    bit  m_inburst = 0, started = 0;
    bit  exp_v = 0, exp_ovf = 0;
    int  exp_ch = 0;
    logic [63:0] exp_d = '0;

    always @(posedge clk) begin
        int  k;
        bit  busy;
        started = 1;
        if (rst) begin
            drain_pos = -1; m_cnt = 0; m_mats = 0; m_inburst = 0;
            exp_v = 0; exp_ovf = 0;
        end else begin
            busy = (drain_pos >= 0);
            if (drain_pos >= 0) begin
                exp_v  = 1;
                exp_ch = drain_pos % C;
                exp_d  = drain_buf[exp_ch * T + drain_pos / C];
                drain_pos++;
                if (drain_pos == BW) drain_pos = -1;
            end else begin
                exp_v = 0;
            end
            if (in_valid) begin
                k = m_inburst ? m_cnt : 0;
                if (int'(in_chan) < C) fill_buf[int'(in_chan) * T + k] = in_data;
                m_cnt = (k == T - 1) ? 0 : k + 1;
                if (k == T - 1) begin
                    if (m_mats == C - 1) begin
                        m_mats = 0;
                        if (busy) exp_ovf = 1;
                        else begin
                            for (int i = 0; i < BW; i++) drain_buf[i] = fill_buf[i];
                            drain_pos = 0;
                        end
                    end else begin
                        m_mats++;
                    end
                end
            end
            m_inburst = in_valid;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(out_valid == exp_v, "R2 R4 out_valid", 64'(out_valid), 64'(exp_v));
            check(overflow == exp_ovf, "R6 R7 overflow", 64'(overflow), 64'(exp_ovf));
            if (exp_v && out_valid) begin
                check(int'(out_chan) == exp_ch, "R3 out_chan", 64'(out_chan), 64'(exp_ch));
                check(out_data == exp_d, "R1 R5 out_data", out_data, exp_d);
            end
        end
    end

    function automatic logic [63:0] pat(input int b, input int ch, input int k);
        return {8'(b), 8'(ch), 16'(k), 32'(b * 40503 + ch * 977 + k * 31) ^ 32'h5A3C_96E1};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_matrix(input int b, input int ch, input int words, input int gap);
        for (int k = 0; k < words; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_chan  = 8'(ch);
            in_data  = pat(b, ch, k);
        end
        idle(gap);
    endtask

    task automatic send_batch(input int b, input int gap);
        for (int ch = 0; ch < C; ch++) send_matrix(b, ch, T, gap);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R8 reset state
                check(out_valid == 1'b0, "R8 out_valid in reset", 64'(out_valid), 64'd0);
                check(overflow == 1'b0, "R8 overflow in reset", 64'(overflow), 64'd0);
                rst = 1'b0;
                // R2 R6: two spaced batches, second fills while first drains
                send_batch(1, 3);
                send_batch(2, 3);
                idle(120);
                // R1: partial burst then restart of element index
                send_matrix(9, 0, 2, 2);
                send_batch(3, 2);
                idle(120);
                // R6: back-to-back batches, second completes during drain
                send_batch(4, 0);
                send_batch(5, 0);
                idle(10);
                check(overflow == 1'b1, "R6 overflow raised", 64'(overflow), 64'd1);
                send_batch(6, 3);
                idle(120);
                // R7 still set
                check(overflow == 1'b1, "R7 overflow sticky", 64'(overflow), 64'd1);
                // R8: reset in mid batch
                for (int ch = 0; ch < 5; ch++) send_matrix(7, ch, T, 3);
                @(negedge clk);
                rst = 1'b1;
                idle(2);
                check(overflow == 1'b0, "R8 overflow cleared", 64'(overflow), 64'd0);
                check(out_valid == 1'b0, "R8 out_valid held low", 64'(out_valid), 64'd0);
                rst = 1'b0;
                send_batch(8, 3);
                idle(120);
            end
            begin
                repeat (50000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL R4 watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule